// File: doc/BRIEF.md
# Bit-Synchronous Frame Receiver with Frame Status Queue

This block receives a bit-synchronous, flag-delimited serial link after clock recovery has been done elsewhere. A one-cycle strobe marks each received line bit. The block finds frame boundaries and abort sequences and removes inserted zeros. It assembles the bits into bytes, least significant bit first, and checks the 16-bit frame check sequence. Every byte of a frame goes into an 8-entry byte queue, including the two check bytes at its end. When a frame closes, either by a flag or by an abort, a 19-bit summary word goes into a separate 10-entry summary queue. A processor reads the two queues independently.

Both read sides use valid/ready. `dat_valid` is high whenever the byte queue holds data. The byte at its head stays on `dat_byte` until a cycle in which `dat_valid` and `dat_ready` are both high, and that cycle consumes it. The summary side follows the same rule with `sts_valid`, `sts_ready` and `sts_word`. The serial side has no back-pressure. A byte that finds the queue full is lost, and the frame's summary records the loss. Error conditions never block the byte queue: the bytes of a later frame are stored without any action by the processor.

Top module: `sdlc_rx`

## Requirements
- R1: A raw 01111110 sequence (zero, six ones, zero), received when no zero is being removed, is a flag. A flag opens a frame, and a flag after a frame that has at least one completed byte closes it. A flag with no completed bytes since the previous flag writes no summary word.
- R2: A zero that arrives right after five consecutive ones is deleted from the data. Data bits are assembled least significant bit first.
- R3: Seven consecutive ones abort the open frame. If the frame had completed at least one byte, its summary word has abort=1, end=0, residue=0, crcerr=0 and the count of stored bytes. Until the next flag, no further bits are stored.
- R4: Each completed byte of a frame goes to the byte queue, including the two check bytes, and the count in the summary word includes them.
- R5: The check uses the polynomial x^16+x^12+x^5+1, bit-reversed (0x8408), with a start value of 0xFFFF. It is run over every completed byte. For a frame closed by a flag, crcerr (bit 14) is 0 exactly when the final remainder is 0xF0B8.
- R6: Summary word layout: bits 13:0 count of stored bytes, 14 crcerr, 15 abort, 16 overrun, 17 end (closed by a flag), 18 residue. Exactly one of end and abort is 1.
- R7: residue is 1 when the closing flag follows a whole number of bytes. Otherwise it is 0, and the bits that filled up a byte together with the flag's leading bits are stored as that byte.
- R8: The byte queue holds 8 bytes. A byte that completes while the queue is full and is not being read is dropped. The summary then sets overrun, and the count leaves the dropped byte out.
- R9: A byte that completes in the same cycle as a read of a full byte queue is stored, and no overrun is recorded.
- R10: `irq` is high when the byte queue holds at least `rx_lvl` bytes, with 0 treated as 1, or when the summary queue is not empty.
- R11: After a frame that closes with a check error or an abort, the bytes of the next frame are stored without any processor action.
- R12: The summary queue holds 10 words. A summary word produced while the queue is full is discarded.
- R13: While `dat_valid` or `sts_valid` is high and the matching ready is low, the valid signal stays high and the data stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Strobe: one received line bit in this cycle |
| rx_bit | input | 1 | Line bit value, taken when rx_en is high |
| rx_lvl | input | 4 | Byte-queue fill level for the interrupt |
| dat_valid | output | 1 | Byte queue not empty |
| dat_ready | input | 1 | Consume the head byte |
| dat_byte | output | 8 | Head byte of the byte queue |
| sts_valid | output | 1 | Summary queue not empty |
| sts_ready | input | 1 | Consume the head summary word |
| sts_word | output | 19 | Head summary word |
| irq | output | 1 | Interrupt request |

## Verification
A received byte can be written into the byte queue in the same cycle that the processor reads from that queue while it is full. The bench fills the queue with eight bytes of one frame. It then raises `dat_ready` for exactly the cycle in which the ninth byte is written, one cycle after the strobe of that byte's last bit. It judges the outcome by reading every byte back in order and by the frame's summary word, which must show nine bytes and overrun cleared.

// File: rtl/sdlc_rx_pkg.sv
package sdlc_rx_pkg;
  localparam int CNT_W = 14;
  localparam logic [15:0] FCS_POLY = 16'h8408;
  localparam logic [15:0] FCS_INIT = 16'hFFFF;
  localparam logic [15:0] FCS_GOOD = 16'hF0B8;

  typedef struct packed {
    logic             res_ok;
    logic             eof;
    logic             ovr;
    logic             abort;
    logic             crc_err;
    logic [CNT_W-1:0] count;
  } sts_t;

  localparam int STS_W = $bits(sts_t);

  function automatic logic [15:0] fcs_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ FCS_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/sdlc_rx_fifo.sv
module sdlc_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rp_q, wp_q;
  logic [CW-1:0] cnt_q;
  logic          rd_ok, wr_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rd_ok = pop && (cnt_q != '0);
  assign wr_ok = push && ((cnt_q != CW'(DEPTH)) || rd_ok);
  assign rdata = mem[rp_q];
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp_q  <= '0;
      wp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (rd_ok) rp_q <= nxt(rp_q);
      if (wr_ok) wp_q <= nxt(wp_q);
      cnt_q <= cnt_q + CW'(wr_ok) - CW'(rd_ok);
    end
  end
endmodule

// File: rtl/sdlc_rx_deframer.sv
module sdlc_rx_deframer
  import sdlc_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       bit_in,
  output logic       byte_vld,
  output logic [7:0] byte_out,
  output logic       end_vld,
  output logic       end_abort,
  output logic       end_res_ok,
  output logic       end_crc_ok
);
  logic [2:0]  ones_q;
  logic [2:0]  cnt_q;
  logic [7:0]  sh_q;
  logic [15:0] crc_q;
  logic        in_frame_q, seen_q;
  logic        is_flag, is_abort, is_data;
  logic [7:0]  sh_nxt;

  assign is_flag  = bit_en && !bit_in && (ones_q == 3'd6);
  assign is_abort = bit_en &&  bit_in && (ones_q == 3'd6);
  assign is_data  = bit_en && (ones_q < 3'd5);
  assign sh_nxt   = {bit_in, sh_q[7:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_q     <= '0;
      cnt_q      <= '0;
      sh_q       <= '0;
      crc_q      <= FCS_INIT;
      in_frame_q <= 1'b0;
      seen_q     <= 1'b0;
      byte_vld   <= 1'b0;
      byte_out   <= '0;
      end_vld    <= 1'b0;
      end_abort  <= 1'b0;
      end_res_ok <= 1'b0;
      end_crc_ok <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      end_vld  <= 1'b0;
      if (bit_en) ones_q <= bit_in ? ((ones_q == 3'd7) ? 3'd7 : ones_q + 3'd1) : 3'd0;
      if (is_flag) begin
        if (in_frame_q && seen_q) begin
          end_vld    <= 1'b1;
          end_abort  <= 1'b0;
          end_res_ok <= (cnt_q == 3'd6);
          end_crc_ok <= (crc_q == FCS_GOOD);
        end
        in_frame_q <= 1'b1;
        seen_q     <= 1'b0;
        cnt_q      <= '0;
        crc_q      <= FCS_INIT;
      end else if (is_abort) begin
        if (in_frame_q && seen_q) begin
          end_vld    <= 1'b1;
          end_abort  <= 1'b1;
          end_res_ok <= 1'b0;
          end_crc_ok <= 1'b1;
        end
        in_frame_q <= 1'b0;
        seen_q     <= 1'b0;
      end else if (is_data && in_frame_q) begin
        sh_q  <= sh_nxt;
        cnt_q <= cnt_q + 3'd1;
        if (cnt_q == 3'd7) begin
          byte_vld <= 1'b1;
          byte_out <= sh_nxt;
          crc_q    <= fcs_step(crc_q, sh_nxt);
          seen_q   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdlc_rx.sv
module sdlc_rx
  import sdlc_rx_pkg::*;
#(
  parameter int DAT_DEPTH = 8,
  parameter int STS_DEPTH = 10,
  localparam int DCW      = $clog2(DAT_DEPTH + 1),
  localparam int SCW      = $clog2(STS_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             rx_bit,
  input  logic [DCW-1:0]   rx_lvl,
  output logic             dat_valid,
  input  logic             dat_ready,
  output logic [7:0]       dat_byte,
  output logic             sts_valid,
  input  logic             sts_ready,
  output logic [STS_W-1:0] sts_word,
  output logic             irq
);
  logic           byte_vld, end_vld, end_abort, end_res_ok, end_crc_ok;
  logic [7:0]     byte_d;
  logic [DCW-1:0] d_count, lvl_eff;
  logic [SCW-1:0] s_count;
  logic           dat_pop, d_wr_ok;
  logic [CNT_W-1:0] acc_cnt_q;
  logic           acc_ovr_q, sts_push_q;
  sts_t           sts_q;

  sdlc_rx_deframer u_deframer (
    .clk(clk), .rst_n(rst_n), .bit_en(rx_en), .bit_in(rx_bit),
    .byte_vld(byte_vld), .byte_out(byte_d),
    .end_vld(end_vld), .end_abort(end_abort),
    .end_res_ok(end_res_ok), .end_crc_ok(end_crc_ok)
  );

  sdlc_rx_fifo #(.W(8), .DEPTH(DAT_DEPTH)) u_dat_fifo (
    .clk(clk), .rst_n(rst_n), .push(byte_vld), .wdata(byte_d),
    .pop(dat_pop), .rdata(dat_byte), .count(d_count)
  );

  sdlc_rx_fifo #(.W(STS_W), .DEPTH(STS_DEPTH)) u_sts_fifo (
    .clk(clk), .rst_n(rst_n), .push(sts_push_q), .wdata(sts_q),
    .pop(sts_ready), .rdata(sts_word), .count(s_count)
  );

  assign dat_valid = (d_count != '0);
  assign sts_valid = (s_count != '0);
  assign dat_pop   = dat_ready && dat_valid;
  assign d_wr_ok   = (d_count != DCW'(DAT_DEPTH)) || dat_pop;
  assign lvl_eff   = (rx_lvl == '0) ? DCW'(1) : rx_lvl;
  assign irq       = (d_count >= lvl_eff) || sts_valid;

  // Per-frame accounting of bytes actually stored and bytes lost.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_cnt_q  <= '0;
      acc_ovr_q  <= 1'b0;
      sts_push_q <= 1'b0;
      sts_q      <= '0;
    end else begin
      sts_push_q <= 1'b0;
      if (byte_vld) begin
        if (d_wr_ok) acc_cnt_q <= acc_cnt_q + 1'b1;
        else         acc_ovr_q <= 1'b1;
      end
      if (end_vld) begin
        sts_push_q    <= 1'b1;
        sts_q.count   <= acc_cnt_q;
        sts_q.ovr     <= acc_ovr_q;
        sts_q.abort   <= end_abort;
        sts_q.eof     <= !end_abort;
        sts_q.res_ok  <= end_res_ok;
        sts_q.crc_err <= !end_crc_ok;
        acc_cnt_q     <= '0;
        acc_ovr_q     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdlc_rx_chk.sv
module sdlc_rx_chk #(
  parameter int DAT_DEPTH = 8,
  localparam int DCW      = $clog2(DAT_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [DCW-1:0] rx_lvl,
  input logic           dat_valid,
  input logic           dat_ready,
  input logic [7:0]     dat_byte,
  input logic           sts_valid,
  input logic           sts_ready,
  input logic [18:0]    sts_word,
  input logic           irq
);
  p_dat_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid && !dat_ready |=> dat_valid && $stable(dat_byte));
  p_sts_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid && !sts_ready |=> sts_valid && $stable(sts_word));
  p_one_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |-> $countones({sts_word[17], sts_word[15]}) == 1);
  p_abort_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid && sts_word[15] |-> !sts_word[18] && !sts_word[14]);
  p_irq_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_lvl <= DCW'(1)) && dat_valid |-> irq);
  p_irq_sts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |-> irq);
endmodule

bind sdlc_rx sdlc_rx_chk #(.DAT_DEPTH(DAT_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_lvl(rx_lvl), .dat_valid(dat_valid),
  .dat_ready(dat_ready), .dat_byte(dat_byte), .sts_valid(sts_valid),
  .sts_ready(sts_ready), .sts_word(sts_word), .irq(irq)
);

// File: tb/sdlc_rx_tb_top.sv
module sdlc_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0, rx_bit = 1'b0;
  logic [3:0]  rx_lvl = 4'd1;
  logic        dat_valid, dat_ready = 1'b0;
  logic [7:0]  dat_byte;
  logic        sts_valid, sts_ready = 1'b0;
  logic [18:0] sts_word;
  logic        irq;

  int checks = 0, failures = 0;
  int tb_ones = 0;
  logic [15:0] tb_crc = 16'hFFFF;
  logic [7:0]  sent_q[$];
  logic [7:0]  popped_b;

  always #10 clk = ~clk;

  sdlc_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit), .rx_lvl(rx_lvl),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
    .sts_valid(sts_valid), .sts_ready(sts_ready), .sts_word(sts_word), .irq(irq)
  );

  function automatic logic [15:0] crc8(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  function automatic logic [18:0] mk(input bit res, eof, ovr, ab, ce, input int cnt);
    return {res, eof, ovr, ab, ce, 14'(cnt)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input bit b, input bit pop);
    @(negedge clk); rx_en = 1'b1; rx_bit = b;
    @(negedge clk); rx_en = 1'b0;
    if (pop) begin
      popped_b = dat_byte; dat_ready = 1'b1;
      @(negedge clk); dat_ready = 1'b0;
    end
  endtask

  task automatic send_flag();
    send_bit(0, 0);
    for (int i = 0; i < 6; i++) send_bit(1, 0);
    send_bit(0, 0);
    tb_ones = 0; tb_crc = 16'hFFFF;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit pop_last = 0);
    for (int i = 0; i < 8; i++) begin
      send_bit(d[i], pop_last && (i == 7));
      if (d[i]) begin
        tb_ones++;
        if (tb_ones == 5) begin send_bit(0, 0); tb_ones = 0; end
      end else tb_ones = 0;
    end
    tb_crc = crc8(tb_crc, d);
    sent_q.push_back(d);
  endtask

  task automatic send_fcs(input bit good);
    logic [15:0] f = ~tb_crc;
    if (!good) f = f ^ 16'h0001;
    send_byte(f[7:0]);
    send_byte(f[15:8]);
  endtask

  task automatic read_byte(input string tag);
    logic [7:0] e;
    for (int k = 0; k < 100 && !dat_valid; k++) @(negedge clk);
    e = (sent_q.size() != 0) ? sent_q.pop_front() : 8'h00;
    check(dat_valid && dat_byte == e, tag, dat_byte, e);
    dat_ready = 1'b1; @(negedge clk); dat_ready = 1'b0;
  endtask

  task automatic read_sts(input string tag, input logic [18:0] e);
    for (int k = 0; k < 100 && !sts_valid; k++) @(negedge clk);
    check(sts_valid && sts_word == e, tag, sts_word, e);
    sts_ready = 1'b1; @(negedge clk); sts_ready = 1'b0;
  endtask

  task automatic t_reset();
    check(!dat_valid && !sts_valid && !irq, "R10 reset outputs idle",
          {dat_valid, sts_valid, irq}, 0);
  endtask

  task automatic t_idle_flags();
    send_flag(); send_flag(); send_flag();
    repeat (4) @(negedge clk);
    check(!sts_valid && !dat_valid, "R1 idle flags give no entry", {sts_valid, dat_valid}, 0);
  endtask

  task automatic t_good_frame();
    logic [7:0] h;
    send_flag();
    send_byte(8'hFF); send_byte(8'h7C); send_byte(8'h7E); send_fcs(1);
    send_flag();
    repeat (3) @(negedge clk);
    check(irq, "R10 irq on first byte", irq, 1);
    h = dat_byte;
    repeat (3) @(negedge clk);
    check(dat_valid && dat_byte == h, "R13 head held without ready", dat_byte, h);
    for (int i = 0; i < 5; i++) read_byte("R2 R4 destuffed bytes and check bytes");
    read_sts("R5 R6 R7 good frame summary", mk(1, 1, 0, 0, 0, 5));
  endtask

  task automatic t_bad_then_good();
    send_flag();
    send_byte(8'h12); send_byte(8'h34); send_fcs(0);
    send_flag();
    send_byte(8'hA5); send_fcs(1);
    send_flag();
    repeat (3) @(negedge clk);
    read_sts("R5 check error flagged", mk(1, 1, 0, 0, 1, 4));
    read_sts("R11 next frame after error", mk(1, 1, 0, 0, 0, 3));
    for (int i = 0; i < 7; i++) read_byte("R11 bytes of both frames");
  endtask

  task automatic t_abort();
    send_flag();
    send_byte(8'h3C); send_byte(8'h81);
    for (int i = 0; i < 7; i++) send_bit(1, 0);
    tb_ones = 0;
    send_bit(0, 0); send_bit(1, 0); send_bit(0, 0); send_bit(1, 0);
    send_bit(0, 0); send_bit(0, 0); send_bit(1, 0); send_bit(1, 0); send_bit(0, 0);
    repeat (3) @(negedge clk);
    read_sts("R3 aborted frame summary", mk(0, 0, 0, 1, 0, 2));
    read_byte("R3 stored bytes before abort");
    read_byte("R3 stored bytes before abort");
    check(!dat_valid, "R3 bits after abort ignored", dat_valid, 0);
    send_flag(); send_byte(8'h5A); send_fcs(1); send_flag();
    repeat (3) @(negedge clk);
    read_sts("R11 frame after abort", mk(1, 1, 0, 0, 0, 3));
    for (int i = 0; i < 3; i++) read_byte("R11 bytes after abort");
  endtask

  task automatic t_residue();
    logic [15:0] c;
    send_flag();
    send_byte(8'h11); send_byte(8'h22);
    send_bit(1, 0); send_bit(0, 0); send_bit(1, 0);
    c = crc8(tb_crc, 8'hF5);
    sent_q.push_back(8'hF5);
    send_flag();
    repeat (3) @(negedge clk);
    read_sts("R7 residue frame summary", mk(0, 1, 0, 0, c != 16'hF0B8, 3));
    for (int i = 0; i < 3; i++) read_byte("R7 residue bytes");
  endtask

  task automatic t_overrun();
    rx_lvl = 4'd8;
    send_flag();
    for (int i = 0; i < 7; i++) send_byte(8'(8'h40 + i));
    repeat (3) @(negedge clk);
    check(!irq, "R10 irq low below level", irq, 0);
    send_byte(8'h47);
    repeat (3) @(negedge clk);
    check(irq, "R10 irq at level", irq, 1);
    send_fcs(1);
    send_flag();
    repeat (3) @(negedge clk);
    read_sts("R8 overrun summary", mk(1, 1, 1, 0, 0, 8));
    for (int i = 0; i < 8; i++) read_byte("R8 stored bytes before overrun");
    check(!dat_valid, "R8 dropped bytes absent", dat_valid, 0);
    sent_q.delete();
    rx_lvl = 4'd1;
  endtask

  task automatic t_same_cycle();
    logic [7:0] e;
    send_flag();
    for (int i = 0; i < 7; i++) send_byte(8'(8'h90 + i));
    begin
      logic [15:0] f = ~tb_crc;
      send_byte(f[7:0]);
      send_byte(f[15:8], 1);
    end
    e = sent_q.pop_front();
    check(popped_b == e, "R9 read during push", popped_b, e);
    send_flag();
    repeat (3) @(negedge clk);
    read_sts("R9 no overrun on simultaneous read", mk(1, 1, 0, 0, 0, 9));
    for (int i = 0; i < 8; i++) read_byte("R9 remaining bytes");
  endtask

  task automatic t_sts_full();
    int n = 0;
    for (int f = 0; f < 11; f++) begin
      send_flag(); send_byte(8'(f)); send_fcs(1);
      send_flag();
      repeat (3) @(negedge clk);
      for (int i = 0; i < 3; i++) read_byte("R12 frame bytes");
    end
    for (int k = 0; k < 12; k++) begin
      if (sts_valid) begin
        check(sts_word == mk(1, 1, 0, 0, 0, 3), "R12 queued summary", sts_word, mk(1, 1, 0, 0, 0, 3));
        sts_ready = 1'b1; @(negedge clk); sts_ready = 1'b0;
        n++;
      end
    end
    check(n == 10, "R12 ten summaries kept", n, 10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_flags();
    t_good_frame();
    t_bad_then_good();
    t_abort();
    t_residue();
    t_overrun();
    t_same_cycle();
    t_sts_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule